// File: doc/BRIEF.md
# Memory request partition tagger

This block sits on a processor's memory request path and gives each accepted request a resource-partition label. The label has three parts: a partition number, a performance monitoring group, and a non-secure marker. Every request carries the current privilege level (0 to 3), the security state, whether the hypervisor level is active, whether level 0 runs in host mode, the trap-general control, and whether the access is an instruction fetch or a data access. Descriptor fetches from the page-table walker enter through the same port. Their fetch/data select comes from the walk that issued them.

The block is configured through a plain write port. That port holds one identifier word for each privilege level, the top-level control flags, the hypervisor control bits, the limits register, and a small table that translates virtual partitions to physical ones. The table lookup is a separate sub-block instantiated inside the tagger. The label is registered. It appears together with a one-cycle valid pulse on the cycle after the request is accepted.

Top module: `part_tagger`

## Requirements
- R1: `tag_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low in every other cycle.
- R2: If `part_impl` is low, or the enable flag (bit 24 of the word at address 3) is clear, the result has `tag_tagged`=0 and `tag_pid`, `tag_pmg` and `tag_ns` all 0. Otherwise `tag_tagged`=1.
- R3: Each identifier word (addresses 0 to 3, one per level) holds the data partition in bits [7:0], the instruction partition in [15:8], the data group in [19:16] and the instruction group in [23:20]. A request with `req_ifetch`=1 uses the instruction fields. Any other request uses the data fields.
- R4: A level-0 request with `req_hyp_en`=1, the guest-lock bit set (bit 2 of address 4) and `req_tge`=0 uses the level-1 word and is treated as level 1 in every later step.
- R5: The limits word (address 5) holds the maximum partition in [7:0] and the maximum group in [11:8]. A partition from the selected word that exceeds its maximum becomes 0. A group that exceeds its maximum becomes 0.
- R6: Virtual translation is used only when the hypervisor-control capability (bit 13 of address 5) is set, `req_hyp_en`=1, and one of two cases holds. Either the effective level is 0, `req_host`=0 and bit 0 of address 4 is set, or the effective level is 1 and bit 1 of address 4 is set. In every other case the in-range partition goes out unchanged.
- R7: For translation, the virtual partition v is first folded. If v exceeds the highest virtual slot (bits [16:14] of address 5), v is replaced by v modulo (that value + 1). The valid mask is at address 6 and the physical entry for slot i is at address 8+i. If slot v is valid, its entry is used. Otherwise slot 0's entry is used if slot 0 is valid. If neither slot is valid, or the entry exceeds the maximum partition, the partition is 0.
- R8: If the secure-default capability (bit 12 of address 5), the secure-default flag (bit 25 of address 3) and `req_secure` are all 1, the partition and group are both 0, whatever R3 to R7 would give.
- R9: On a tagged request, `tag_ns` is 1 when `req_secure`=0 or when the force flag (bit 26 of address 3) is set. Otherwise it is 0.
- R10: After reset `tag_valid` is low and every configuration word is 0, so requests come out untagged until the enable flag is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| part_impl | input | 1 | Partitioning feature present |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration word address |
| wr_data | input | 27 | Configuration write data |
| req_valid | input | 1 | Request accepted this cycle |
| req_el | input | 2 | Privilege level of the request |
| req_secure | input | 1 | Requester is in the secure state |
| req_hyp_en | input | 1 | Hypervisor level is enabled |
| req_host | input | 1 | Level 0 runs in host mode |
| req_tge | input | 1 | Trap-general control |
| req_ifetch | input | 1 | 1 for an instruction fetch, 0 for data |
| tag_valid | output | 1 | Label valid pulse |
| tag_tagged | output | 1 | Request carries a label |
| tag_pid | output | 8 | Partition number |
| tag_pmg | output | 4 | Monitoring group |
| tag_ns | output | 1 | Non-secure marker |

## Verification
The bench steps through many configurations. For each one it applies every combination of level, security, hypervisor, host, trap and fetch inputs, and compares the result with an arithmetic model. The model covers several faults. A design that skipped the guest redirect would read the level-0 word for guest applications. One that applied the limit after translation instead of before would send an out-of-range virtual number through the table. One that dropped the modulo fold or the slot-0 fallback would return an entry from the wrong slot or a spurious zero. One that ordered the secure-default or the force flag wrongly would leak identifiers or the wrong non-secure marker on secure requests. The configurations include an empty valid mask, table entries above the limit, and a missing feature.

// File: rtl/part_tag_pkg.sv
package part_tag_pkg;
  localparam int PID_W    = 8;
  localparam int PMG_W    = 4;
  localparam int VSLOTS   = 8;
  localparam int VSL_W    = $clog2(VSLOTS);
  localparam int MAP_BASE = 8;
  localparam int AW       = $clog2(MAP_BASE + VSLOTS);
  localparam int IDS_W    = 2 * PID_W + 2 * PMG_W;
  localparam int DW       = IDS_W + 3;

  typedef logic [PID_W-1:0] pid_t;
  typedef logic [PMG_W-1:0] pmg_t;

  // per-level identifier word, LSB first: pid_d, pid_i, pmg_d, pmg_i
  typedef struct packed {
    pmg_t pmg_i;
    pmg_t pmg_d;
    pid_t pid_i;
    pid_t pid_d;
  } ids_t;

  typedef struct packed {
    logic force_ns;
    logic sdeflt;
    logic en;
  } topflg_t;

  typedef struct packed {
    logic guest_lock;
    logic el1_vmen;
    logic el0_vmen;
  } hctl_t;

  typedef struct packed {
    logic [VSL_W-1:0] vid_max;
    logic             has_hcr;
    logic             has_sdeflt;
    pmg_t             pmg_max;
    pid_t             pid_max;
  } limits_t;

  function automatic pid_t pid_limit(pid_t v, pid_t mx);
    return (v > mx) ? '0 : v;
  endfunction

  function automatic pmg_t pmg_limit(pmg_t v, pmg_t mx);
    return (v > mx) ? '0 : v;
  endfunction

  // fold an out-of-range virtual partition onto the implemented slots
  function automatic logic [VSL_W-1:0] vslot_fold(pid_t v, logic [VSL_W-1:0] vmax);
    pid_t top;
    pid_t r;
    top = pid_t'(vmax);
    r   = (v > top) ? (v % (top + pid_t'(1))) : v;
    return r[VSL_W-1:0];
  endfunction
endpackage

// File: rtl/pt_regfile.sv
module pt_regfile
  import part_tag_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  output ids_t  [3:0]         lvl_ids,
  output topflg_t             topflg,
  output hctl_t               hctl,
  output limits_t             lims,
  output logic [VSLOTS-1:0]   vmask,
  output pid_t  [VSLOTS-1:0]  ventry
);
  localparam int LIM_W = $bits(limits_t);

  for (genvar l = 0; l < 4; l++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl_ids[l] <= '0;
      else if (wr_en && wr_addr == AW'(l))
        lvl_ids[l] <= ids_t'(wr_data[IDS_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      topflg <= '0;
      hctl   <= '0;
      lims   <= '0;
      vmask  <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(3)) topflg <= topflg_t'(wr_data[IDS_W +: 3]);
      if (wr_addr == AW'(4)) hctl   <= hctl_t'(wr_data[2:0]);
      if (wr_addr == AW'(5)) lims   <= limits_t'(wr_data[LIM_W-1:0]);
      if (wr_addr == AW'(6)) vmask  <= wr_data[VSLOTS-1:0];
    end
  end

  for (genvar i = 0; i < VSLOTS; i++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ventry[i] <= '0;
      else if (wr_en && wr_addr == AW'(MAP_BASE + i))
        ventry[i] <= wr_data[PID_W-1:0];
    end
  end
endmodule

// File: rtl/pt_select.sv
module pt_select
  import part_tag_pkg::*;
(
  input  logic          req_el_0,
  input  logic          req_el_1,
  input  logic          req_hyp_en,
  input  logic          req_host,
  input  logic          req_tge,
  input  logic          req_ifetch,
  input  ids_t  [3:0]   lvl_ids,
  input  hctl_t         hctl,
  input  logic          has_hcr,
  output logic [1:0]    eff_el,
  output pid_t          pid_raw,
  output pmg_t          pmg_raw,
  output logic          use_virt
);
  logic [1:0] el_in;
  logic       redirect;
  ids_t       ids;

  assign el_in    = {req_el_1, req_el_0};
  assign redirect = (el_in == 2'd0) && req_hyp_en && hctl.guest_lock && !req_tge;
  assign eff_el   = redirect ? 2'd1 : el_in;
  assign ids      = lvl_ids[eff_el];
  assign pid_raw  = req_ifetch ? ids.pid_i : ids.pid_d;
  assign pmg_raw  = req_ifetch ? ids.pmg_i : ids.pmg_d;

  always_comb begin
    use_virt = 1'b0;
    if (has_hcr && req_hyp_en) begin
      if (eff_el == 2'd0)      use_virt = !req_host && hctl.el0_vmen;
      else if (eff_el == 2'd1) use_virt = hctl.el1_vmen;
    end
  end
endmodule

// File: rtl/pt_vmap.sv
module pt_vmap
  import part_tag_pkg::*;
(
  input  pid_t              vid,
  input  logic [VSL_W-1:0]  vid_max,
  input  pid_t              pid_max,
  input  logic [VSLOTS-1:0] vmask,
  input  pid_t [VSLOTS-1:0] ventry,
  output pid_t              phys,
  output logic              map_err
);
  logic [VSL_W-1:0] slot;
  logic             hit;
  logic             dflt;

  assign slot    = vslot_fold(vid, vid_max);
  assign hit     = vmask[slot];
  assign dflt    = vmask[0];
  assign phys    = hit ? ventry[slot] : ventry[0];
  assign map_err = !(hit || dflt) || (phys > pid_max);
endmodule

// File: rtl/part_tagger.sv
module part_tagger
  import part_tag_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  part_impl,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic                  req_valid,
  input  logic [1:0]            req_el,
  input  logic                  req_secure,
  input  logic                  req_hyp_en,
  input  logic                  req_host,
  input  logic                  req_tge,
  input  logic                  req_ifetch,
  output logic                  tag_valid,
  output logic                  tag_tagged,
  output logic [PID_W-1:0]      tag_pid,
  output logic [PMG_W-1:0]      tag_pmg,
  output logic                  tag_ns
);
  ids_t  [3:0]        lvl_ids;
  topflg_t            topflg;
  hctl_t              hctl;
  limits_t            lims;
  logic [VSLOTS-1:0]  vmask;
  pid_t [VSLOTS-1:0]  ventry;

  logic [1:0] eff_el;
  pid_t       pid_raw;
  pmg_t       pmg_raw;
  logic       use_virt;
  pid_t       map_pid;
  logic       map_err;

  // named events for the checker
  logic enabled;
  logic sdef_hit;
  logic frc_ns;
  pid_t lim_pid;
  pmg_t lim_pmg;
  pid_t pid_sel;
  pmg_t pmg_sel;
  logic ns_nxt;

  pt_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lvl_ids (lvl_ids),
    .topflg  (topflg),
    .hctl    (hctl),
    .lims    (lims),
    .vmask   (vmask),
    .ventry  (ventry)
  );

  pt_select u_sel (
    .req_el_0   (req_el[0]),
    .req_el_1   (req_el[1]),
    .req_hyp_en (req_hyp_en),
    .req_host   (req_host),
    .req_tge    (req_tge),
    .req_ifetch (req_ifetch),
    .lvl_ids    (lvl_ids),
    .hctl       (hctl),
    .has_hcr    (lims.has_hcr),
    .eff_el     (eff_el),
    .pid_raw    (pid_raw),
    .pmg_raw    (pmg_raw),
    .use_virt   (use_virt)
  );

  pt_vmap u_vmap (
    .vid     (pid_raw),
    .vid_max (lims.vid_max),
    .pid_max (lims.pid_max),
    .vmask   (vmask),
    .ventry  (ventry),
    .phys    (map_pid),
    .map_err (map_err)
  );

  assign enabled  = part_impl && topflg.en;
  assign sdef_hit = lims.has_sdeflt && topflg.sdeflt && req_secure;
  assign frc_ns   = topflg.force_ns;
  assign lim_pid  = lims.pid_max;
  assign lim_pmg  = lims.pmg_max;

  // range check comes first; translation sees only in-range numbers
  always_comb begin
    if (pid_raw > lims.pid_max) pid_sel = '0;
    else if (use_virt)          pid_sel = map_err ? '0 : map_pid;
    else                        pid_sel = pid_raw;
  end

  assign pmg_sel = pmg_limit(pmg_raw, lims.pmg_max);
  assign ns_nxt  = !req_secure || frc_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_valid  <= 1'b0;
      tag_tagged <= 1'b0;
      tag_pid    <= '0;
      tag_pmg    <= '0;
      tag_ns     <= 1'b0;
    end else begin
      tag_valid <= req_valid;
      if (req_valid) begin
        tag_tagged <= enabled;
        tag_pid    <= (enabled && !sdef_hit) ? pid_sel : '0;
        tag_pmg    <= (enabled && !sdef_hit) ? pmg_sel : '0;
        tag_ns     <= enabled && ns_nxt;
      end
    end
  end
endmodule

// File: rtl/part_tagger_chk.sv
module part_tagger_chk
  import part_tag_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_secure,
  input logic       enabled,
  input logic       sdef_hit,
  input logic       frc_ns,
  input pid_t       lim_pid,
  input pmg_t       lim_pmg,
  input logic       tag_valid,
  input logic       tag_tagged,
  input pid_t       tag_pid,
  input pmg_t       tag_pmg,
  input logic       tag_ns
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> tag_valid);
  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !tag_valid);
  assert_tagged_tracks_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (tag_tagged == $past(enabled)));
  assert_untagged_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_tagged) |-> (tag_pid == '0 && tag_pmg == '0 && !tag_ns));
  assert_pid_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (tag_pid <= $past(lim_pid)));
  assert_pmg_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (tag_pmg <= $past(lim_pmg)));
  assert_secure_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && enabled && sdef_hit) |=> (tag_pid == '0 && tag_pmg == '0));
  assert_ns_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && enabled && (!req_secure || frc_ns)) |=> tag_ns);
  assert_ns_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && enabled && req_secure && !frc_ns) |=> !tag_ns);
endmodule

bind part_tagger part_tagger_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_secure (req_secure),
  .enabled    (enabled),
  .sdef_hit   (sdef_hit),
  .frc_ns     (frc_ns),
  .lim_pid    (lim_pid),
  .lim_pmg    (lim_pmg),
  .tag_valid  (tag_valid),
  .tag_tagged (tag_tagged),
  .tag_pid    (tag_pid),
  .tag_pmg    (tag_pmg),
  .tag_ns     (tag_ns)
);

// File: tb/test_part_tagger.sv
`timescale 1ns/1ps
module test_part_tagger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        part_impl = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [26:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_el = '0;
  logic        req_secure = 1'b0;
  logic        req_hyp_en = 1'b0;
  logic        req_host = 1'b0;
  logic        req_tge = 1'b0;
  logic        req_ifetch = 1'b0;
  logic        tag_valid;
  logic        tag_tagged;
  logic [7:0]  tag_pid;
  logic [3:0]  tag_pmg;
  logic        tag_ns;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // bench copy of the configuration
  int s_pid_d[4], s_pid_i[4], s_pmg_d[4], s_pmg_i[4];
  int s_en, s_sdf, s_fns, s_lock, s_v0, s_v1;
  int s_pmax, s_gmax, s_hs, s_hh, s_vmx, s_vmask;
  int s_ent[8];

  part_tagger i_part_tagger (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string rq, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 27'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_cfg();
    for (int l = 0; l < 4; l++) begin
      int d;
      d = s_pid_d[l] | (s_pid_i[l] << 8) | (s_pmg_d[l] << 16) | (s_pmg_i[l] << 20);
      if (l == 3) d = d | (s_en << 24) | (s_sdf << 25) | (s_fns << 26);
      wr(l, d);
    end
    wr(4, s_v0 | (s_v1 << 1) | (s_lock << 2));
    wr(5, s_pmax | (s_gmax << 8) | (s_hs << 12) | (s_hh << 13) | (s_vmx << 14));
    wr(6, s_vmask);
    for (int i = 0; i < 8; i++) wr(8 + i, s_ent[i]);
  endtask

  // drive one request, sample the registered label one cycle later
  task automatic issue(int el, int sec, int hyp, int host, int tge, int ifc);
    @(negedge clk);
    req_valid = 1'b1; req_el = 2'(el); req_secure = sec[0]; req_hyp_en = hyp[0];
    req_host = host[0]; req_tge = tge[0]; req_ifetch = ifc[0];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_tag(int el, int sec, int hyp, int host, int tge, int ifc);
    int lv, p, g, idx, ph, e_pid, e_pmg, e_ns;
    string rq;
    chk("R1", int'(tag_valid), 1, "valid pulse");
    if (!part_impl || !s_en) begin
      chk("R2", int'(tag_tagged), 0, "tagged");
      chk("R2", int'(tag_pid), 0, "pid");
      chk("R2", int'(tag_pmg), 0, "pmg");
      chk("R2", int'(tag_ns), 0, "ns");
      return;
    end
    chk("R2", int'(tag_tagged), 1, "tagged");
    e_ns = (!sec || s_fns) ? 1 : 0;
    chk("R9", int'(tag_ns), e_ns, "ns");
    if (s_hs && s_sdf && sec) begin
      chk("R8", int'(tag_pid), 0, "pid");
      chk("R8", int'(tag_pmg), 0, "pmg");
      return;
    end
    lv = (el == 0 && hyp && s_lock && !tge) ? 1 : el;
    p  = ifc ? s_pid_i[lv] : s_pid_d[lv];
    g  = ifc ? s_pmg_i[lv] : s_pmg_d[lv];
    e_pmg = (g > s_gmax) ? 0 : g;
    if (p > s_pmax) begin
      e_pid = 0; rq = "R5";
    end else if (s_hh && hyp && ((lv == 0 && !host && s_v0) || (lv == 1 && s_v1))) begin
      idx = (p > s_vmx) ? p % (s_vmx + 1) : p;
      if ((s_vmask >> idx) & 1)  ph = s_ent[idx];
      else if (s_vmask & 1)      ph = s_ent[0];
      else                       ph = -1;
      e_pid = (ph < 0 || ph > s_pmax) ? 0 : ph;
      rq = "R7";
    end else begin
      e_pid = p;
      rq = (lv != el) ? "R4" : (hyp ? "R6" : "R3");
    end
    chk(rq, int'(tag_pid), e_pid, "pid");
    chk("R5", int'(tag_pmg), e_pmg, "pmg");
  endtask

  task automatic make_cfg(int c);
    for (int l = 0; l < 4; l++) begin
      s_pid_d[l] = (37 * l + 11 * c + 3) & 255;
      s_pid_i[l] = (91 * l + 29 * c + 200) & 255;
      s_pmg_d[l] = (5 * l + c) & 15;
      s_pmg_i[l] = (7 * l + 3 * c + 9) & 15;
    end
    s_en    = ((c % 8) != 7) ? 1 : 0;
    s_sdf   = (c >> 1) & 1;
    s_fns   = (c >> 2) & 1;
    s_lock  = c & 1;
    s_v0    = ((c >> 1) ^ (c >> 3) ^ 1) & 1;
    s_v1    = ((c >> 2) ^ 1) & 1;
    s_pmax  = ((c >> 3) & 1) ? 255 : 150;
    s_gmax  = 9 + (c & 3);
    s_hs    = (c ^ (c >> 2)) & 1;
    s_hh    = (((c >> 1) & 1) == 0 || ((c >> 3) & 1)) ? 1 : 0;
    s_vmx   = c % 8;
    s_vmask = (c == 5) ? 0 : ((c * 73 + 1) & 255);
    for (int i = 0; i < 8; i++) s_ent[i] = (i * 45 + c * 17 + 60) & 255;
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", int'(tag_valid), 0, "valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", int'(tag_valid), 0, "valid after reset");
    part_impl = 1'b1;
    issue(1, 0, 0, 0, 0, 0);
    chk("R10", int'(tag_tagged), 0, "untagged before config");
    chk("R10", int'(tag_pid) + int'(tag_pmg) + int'(tag_ns), 0, "empty label");
    @(negedge clk);
    chk("R1", int'(tag_valid), 0, "no valid without request");

    for (int c = 0; c < 16; c++) begin
      make_cfg(c);
      part_impl = (c != 12);
      load_cfg();
      for (int k = 0; k < 128; k++) begin
        issue(k & 3, (k >> 2) & 1, (k >> 3) & 1, (k >> 4) & 1, (k >> 5) & 1, (k >> 6) & 1);
        expect_tag(k & 3, (k >> 2) & 1, (k >> 3) & 1, (k >> 4) & 1, (k >> 5) & 1, (k >> 6) & 1);
      end
    end

    // R1: back-to-back requests each produce a pulse, then it drops
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    chk("R1", int'(tag_valid), 1, "first of pair");
    @(negedge clk);
    chk("R1", int'(tag_valid), 1, "second of pair");
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1", int'(tag_valid), 0, "after pair");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule